// File: doc/BRIEF.md
# Time-Stamping Address-Event Monitor

This block sits behind the arbiter of an address-event bus and records each completed handshake as a short group of typed 18-bit words. It writes these words into a downstream FIFO through a plain write port. The two top bits of every word give its kind, so software draining the FIFO can find the start of the next event even after words have been lost. An optional time stamp is taken from a free-running 32-bit counter. That counter advances on a slow tick whose period can be chosen, and configuration inputs can freeze it or force it to zero.

A per-channel ignore mask drops events from chosen sources before they reach the FIFO. When the arbiter merges several sources, the channel comes from the top two address bits. The block writes an event only when the whole group fits. Otherwise it drops the event and counts it, so the FIFO never holds a partial group. Two sticky interrupt flags report the FIFO reaching half occupancy and reaching full. Each flag can be disabled, and a write with a clear mask resets either flag.

Top module: `aer_event_monitor`

## Requirements
- R1: Each FIFO word has its kind in bits 17:16 and its payload in bits 15:0. Code 00 is the event address, code 01 is the upper half of the time, code 10 is the lower half of the time, and code 11 is reserved for control.
- R2: With `cfg_stamp_en_n` = 0, an accepted event writes three words in three consecutive cycles, starting the cycle after `ev_valid`. The order is time-high, time-low, address. The time is the `time_value` seen in the cycle where `ev_valid` is high.
- R3: With `cfg_stamp_en_n` = 1, an accepted event writes only its address word, in the cycle after `ev_valid`.
- R4: While `cfg_time_run_n` = 0, `time_value` rises by one per tick period. `cfg_tick_sel` selects the period: 00 gives 1 us, 01 gives 10 us, 10 gives 50 us and 11 gives 100 us, with `CLK_PER_US` clocks per microsecond. While `cfg_time_run_n` = 1, the value holds.
- R5: With `cfg_time_zero_n` = 0, `time_value` is 0 after the next edge and the tick prescaler restarts.
- R6: The source channel is `ev_addr[15:14]` when `cfg_multi_src` = 1, and channel 0 otherwise. An event whose channel bit in `cfg_chan_mask` is 1 writes nothing and is not counted as lost.
- R7: An unmasked event that arrives while the FIFO lacks room is dropped with no word written, and `lost_count` rises by one. Lacking room means `fifo_full` is set when only the address is stored, or `fifo_nearly_full` (fewer than three free slots) is set when time stamps are on.
- R8: An unmasked event that arrives while an earlier group is still being written is dropped and counted in `lost_count`.
- R9: `irq_half_flag` sets on a rising edge of `fifo_half`, but only when `cfg_half_irq_en_n` = 0. It stays set until cleared.
- R10: `irq_full_flag` sets on a rising edge of `fifo_full`, but only when `cfg_full_irq_en_n` = 0. It stays set until cleared.
- R11: A cycle with `flag_clr_we` = 1 clears each flag whose bit in `flag_clr_mask` is 1 (bit 0 is half, bit 1 is full) and leaves the other flag unchanged. `irq` is the OR of both flags.
- R12: After reset, `fifo_wr`, `time_value`, both flags, `irq` and `lost_count` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_tick_sel | input | 2 | Time tick period select |
| cfg_time_run_n | input | 1 | Counter run, active low |
| cfg_time_zero_n | input | 1 | Force counter to zero, active low |
| cfg_stamp_en_n | input | 1 | Time-stamp words on, active low |
| cfg_multi_src | input | 1 | Channel taken from address bits 15:14 |
| cfg_chan_mask | input | 4 | 1 ignores the channel |
| cfg_half_irq_en_n | input | 1 | Half-full flag enable, active low |
| cfg_full_irq_en_n | input | 1 | Full flag enable, active low |
| ev_valid | input | 1 | One-cycle pulse per completed handshake |
| ev_addr | input | 16 | Event address |
| fifo_full | input | 1 | FIFO has no free slot |
| fifo_nearly_full | input | 1 | FIFO has fewer than three free slots |
| fifo_half | input | 1 | FIFO at least half occupied |
| flag_clr_we | input | 1 | Flag clear strobe |
| flag_clr_mask | input | 2 | Flags to clear (bit 0 half, bit 1 full) |
| fifo_wr | output | 1 | FIFO write enable |
| fifo_data | output | 18 | FIFO write word |
| time_value | output | 32 | Current time counter |
| lost_count | output | 16 | Saturating count of dropped events |
| irq_half_flag | output | 1 | Sticky half-full flag |
| irq_full_flag | output | 1 | Sticky full flag |
| irq | output | 1 | Either flag set |

## Verification
The word sequencer is driven with a stamped event carrying a frozen, known time, and the bench compares the words cycle by cycle so that word order and the capture instant can be told apart. Address-only events are run under a channel mask in both merged and single-source modes. This separates the case where the mask uses the top address bits from the case where the channel is fixed at 0. A FIFO filled to two free slots shows whether stamped and unstamped events are judged by different room rules. A back-to-back pulse shows that an event arriving mid-group is dropped rather than interleaved. The timer is run at all four tick periods and sampled half a period away from each step.

// File: rtl/aem_pkg.sv
// Shared word codes and state type for the address-event monitor.
// Assumes an 18-bit FIFO word: 2-bit kind tag above a 16-bit payload.
package aem_pkg;
    localparam int PAYLOAD_W = 16;
    localparam int TAG_W     = 2;
    localparam int WORD_W    = PAYLOAD_W + TAG_W;

    localparam logic [TAG_W-1:0] TAG_ADDR = 2'b00;
    localparam logic [TAG_W-1:0] TAG_THI  = 2'b01;
    localparam logic [TAG_W-1:0] TAG_TLO  = 2'b10;
    localparam logic [TAG_W-1:0] TAG_CTRL = 2'b11;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_THI  = 2'd1,
        SQ_TLO  = 2'd2,
        SQ_ADDR = 2'd3
    } seq_state_e;
endpackage

// File: rtl/aem_time_base.sv
// Time base: a microsecond prescaler, a selectable divider (1/10/50/100 us)
// and a TIME_W-bit elapsed-time counter.
// Assumes CLK_PER_US clock cycles per microsecond; run and zero are active low.
module aem_time_base #(
    parameter int CLK_PER_US = 50,
    parameter int TIME_W     = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        tick_sel,
    input  logic              run_n,
    input  logic              zero_n,
    output logic [TIME_W-1:0] time_q
);
    localparam int US_W  = $clog2(CLK_PER_US + 1);
    localparam int DIV_W = 7;

    logic [US_W-1:0]  us_cnt;
    logic [DIV_W-1:0] div_cnt;
    logic [DIV_W-1:0] div_lim;
    logic             us_end;
    logic             div_end;

    // Map the tick select code to a number of microseconds per tick.
    always_comb begin
        case (tick_sel)
            2'b00:   div_lim = DIV_W'(1);
            2'b01:   div_lim = DIV_W'(10);
            2'b10:   div_lim = DIV_W'(50);
            default: div_lim = DIV_W'(100);
        endcase
    end

    assign us_end  = (us_cnt >= US_W'(CLK_PER_US - 1));
    assign div_end = (div_cnt >= div_lim - DIV_W'(1));

    // Advance prescaler and counter; zero forces all, stop freezes all.
    always_ff @(posedge clk) begin
        if (!rst_n || !zero_n) begin
            us_cnt  <= '0;
            div_cnt <= '0;
            time_q  <= '0;
        end else if (!run_n) begin
            if (us_end) begin
                us_cnt <= '0;
                if (div_end) begin
                    div_cnt <= '0;
                    time_q  <= time_q + TIME_W'(1);
                end else begin
                    div_cnt <= div_cnt + DIV_W'(1);
                end
            end else begin
                us_cnt <= us_cnt + US_W'(1);
            end
        end
    end

    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (run_n && zero_n) |=> $stable(time_q));
    p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_n && zero_n) |=> (time_q == $past(time_q) || time_q == $past(time_q) + TIME_W'(1)));
    p_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !zero_n |=> (time_q == '0));
endmodule

// File: rtl/aem_word_seq.sv
// Event capture and word sequencer: filters events by channel mask, checks
// FIFO room for the whole group, then writes time-high, time-low, address.
// Assumes FIFO flags reflect all writes issued before the current cycle.
module aem_word_seq
    import aem_pkg::*;
#(
    parameter int TIME_W = 32,
    parameter int LOST_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ev_valid,
    input  logic [PAYLOAD_W-1:0] ev_addr,
    input  logic                 stamp_en_n,
    input  logic                 multi_src,
    input  logic [3:0]           chan_mask,
    input  logic [TIME_W-1:0]    time_now,
    input  logic                 fifo_full,
    input  logic                 fifo_nearly_full,
    output logic                 fifo_wr,
    output logic [WORD_W-1:0]    fifo_data,
    output logic [LOST_W-1:0]    lost_count
);
    localparam int HALF_T = TIME_W / 2;

    seq_state_e            state;
    logic [1:0]            chan;
    logic                  masked;
    logic                  room;
    logic                  take;
    logic                  lose;
    logic [TIME_W-1:0]     t_hold;
    logic [PAYLOAD_W-1:0]  a_hold;

    // Decide channel, mask hit, room and the accept/drop outcome.
    always_comb begin
        chan   = multi_src ? ev_addr[PAYLOAD_W-1 -: 2] : 2'd0;
        masked = chan_mask[chan];
        room   = stamp_en_n ? !fifo_full : !fifo_nearly_full;
        take   = ev_valid && !masked && (state == SQ_IDLE) && room;
        lose   = ev_valid && !masked && !take;
    end

    // Step through the word group and latch the event on accept.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= SQ_IDLE;
            t_hold <= '0;
            a_hold <= '0;
        end else begin
            case (state)
                SQ_IDLE: if (take) begin
                    t_hold <= time_now;
                    a_hold <= ev_addr;
                    state  <= stamp_en_n ? SQ_ADDR : SQ_THI;
                end
                SQ_THI:  state <= SQ_TLO;
                SQ_TLO:  state <= SQ_ADDR;
                default: state <= SQ_IDLE;
            endcase
        end
    end

    // Count dropped events, saturating at the top.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lost_count <= '0;
        end else if (lose && lost_count != '1) begin
            lost_count <= lost_count + LOST_W'(1);
        end
    end

    // Drive the write port from the current state.
    always_comb begin
        fifo_wr = (state != SQ_IDLE);
        case (state)
            SQ_THI:  fifo_data = {TAG_THI, t_hold[TIME_W-1 -: HALF_T]};
            SQ_TLO:  fifo_data = {TAG_TLO, t_hold[HALF_T-1:0]};
            default: fifo_data = {TAG_ADDR, a_hold};
        endcase
    end

    p_thi_then_tlo_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_wr && fifo_data[WORD_W-1 -: TAG_W] == TAG_THI)
        |=> (fifo_wr && fifo_data[WORD_W-1 -: TAG_W] == TAG_TLO));
    p_tlo_then_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_wr && fifo_data[WORD_W-1 -: TAG_W] == TAG_TLO)
        |=> (fifo_wr && fifo_data[WORD_W-1 -: TAG_W] == TAG_ADDR));
    p_no_write_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_wr |-> !fifo_full);
    p_masked_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && !fifo_wr && multi_src && chan_mask[ev_addr[PAYLOAD_W-1 -: 2]]) |=> !fifo_wr);
    p_lost_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (lost_count != $past(lost_count)) |-> (lost_count == $past(lost_count) + LOST_W'(1)));
endmodule

// File: rtl/aem_irq_flags.sv
// Sticky interrupt flags for FIFO half-full (index 0) and full (index 1).
// Each sets on a rising edge of its source when enabled (active low) and is
// cleared by a strobe whose mask bit is 1; a new rising edge wins over clear.
module aem_irq_flags #(
    parameter int N_FLAG = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_FLAG-1:0] src,
    input  logic [N_FLAG-1:0] en_n,
    input  logic              clr_we,
    input  logic [N_FLAG-1:0] clr_mask,
    output logic [N_FLAG-1:0] flag
);
    logic [N_FLAG-1:0] src_q;

    for (genvar i = 0; i < N_FLAG; i++) begin : g_flag
        logic set_i;
        logic clr_i;
        assign set_i = src[i] && !src_q[i] && !en_n[i];
        assign clr_i = clr_we && clr_mask[i];

        // Track the source and update the sticky flag.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                src_q[i] <= 1'b0;
                flag[i]  <= 1'b0;
            end else begin
                src_q[i] <= src[i];
                flag[i]  <= set_i || (flag[i] && !clr_i);
            end
        end

        p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (flag[i] && !clr_we) |=> flag[i]);
        p_disabled_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (en_n[i] && !flag[i]) |=> !flag[i]);
        p_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_we && clr_mask[i] && !src[i]) |=> !flag[i]);
    end
endmodule

// File: rtl/aer_event_monitor.sv
// Time-stamping address-event monitor top: time base, word sequencer and
// interrupt flags. Assumes one ev_valid pulse per completed handshake and a
// FIFO whose full/nearly-full/half flags track writes with one cycle of lag.
module aer_event_monitor
    import aem_pkg::*;
#(
    parameter int CLK_PER_US = 50,
    parameter int TIME_W     = 32,
    parameter int LOST_W     = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cfg_tick_sel,
    input  logic              cfg_time_run_n,
    input  logic              cfg_time_zero_n,
    input  logic              cfg_stamp_en_n,
    input  logic              cfg_multi_src,
    input  logic [3:0]        cfg_chan_mask,
    input  logic              cfg_half_irq_en_n,
    input  logic              cfg_full_irq_en_n,
    input  logic              ev_valid,
    input  logic [15:0]       ev_addr,
    input  logic              fifo_full,
    input  logic              fifo_nearly_full,
    input  logic              fifo_half,
    input  logic              flag_clr_we,
    input  logic [1:0]        flag_clr_mask,
    output logic              fifo_wr,
    output logic [17:0]       fifo_data,
    output logic [TIME_W-1:0] time_value,
    output logic [LOST_W-1:0] lost_count,
    output logic              irq_half_flag,
    output logic              irq_full_flag,
    output logic              irq
);
    logic [1:0] flags;

    aem_time_base #(.CLK_PER_US(CLK_PER_US), .TIME_W(TIME_W)) u_time (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_sel (cfg_tick_sel),
        .run_n    (cfg_time_run_n),
        .zero_n   (cfg_time_zero_n),
        .time_q   (time_value)
    );

    aem_word_seq #(.TIME_W(TIME_W), .LOST_W(LOST_W)) u_seq (
        .clk              (clk),
        .rst_n            (rst_n),
        .ev_valid         (ev_valid),
        .ev_addr          (ev_addr),
        .stamp_en_n       (cfg_stamp_en_n),
        .multi_src        (cfg_multi_src),
        .chan_mask        (cfg_chan_mask),
        .time_now         (time_value),
        .fifo_full        (fifo_full),
        .fifo_nearly_full (fifo_nearly_full),
        .fifo_wr          (fifo_wr),
        .fifo_data        (fifo_data),
        .lost_count       (lost_count)
    );

    aem_irq_flags #(.N_FLAG(2)) u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .src      ({fifo_full, fifo_half}),
        .en_n     ({cfg_full_irq_en_n, cfg_half_irq_en_n}),
        .clr_we   (flag_clr_we),
        .clr_mask (flag_clr_mask),
        .flag     (flags)
    );

    assign irq_half_flag = flags[0];
    assign irq_full_flag = flags[1];
    assign irq           = |flags;

    p_irq_r11: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (irq_half_flag || irq_full_flag));
endmodule

// File: tb/aer_event_monitor_bench.sv
// Directed bench: one task per scenario, FIFO modelled as a 16-slot counter.
module aer_event_monitor_bench;
    localparam int DEPTH = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cfg_tick_sel = 2'b00;
    logic        cfg_time_run_n = 1'b1;
    logic        cfg_time_zero_n = 1'b1;
    logic        cfg_stamp_en_n = 1'b1;
    logic        cfg_multi_src = 1'b0;
    logic [3:0]  cfg_chan_mask = 4'b0000;
    logic        cfg_half_irq_en_n = 1'b1;
    logic        cfg_full_irq_en_n = 1'b1;
    logic        ev_valid = 1'b0;
    logic [15:0] ev_addr = 16'h0;
    logic        flag_clr_we = 1'b0;
    logic [1:0]  flag_clr_mask = 2'b00;
    logic        fifo_full, fifo_nearly_full, fifo_half;
    logic        fifo_wr;
    logic [17:0] fifo_data;
    logic [31:0] time_value;
    logic [15:0] lost_count;
    logic        irq_half_flag, irq_full_flag, irq;

    logic        drain = 1'b0;
    logic [4:0]  cnt;
    logic [17:0] cap [0:31];

    int checks = 0;
    int errors = 0;
    int exp_lost = 0;

    always #10 clk = ~clk;

    aer_event_monitor u_aer_event_monitor (
        .clk(clk), .rst_n(rst_n), .cfg_tick_sel(cfg_tick_sel),
        .cfg_time_run_n(cfg_time_run_n), .cfg_time_zero_n(cfg_time_zero_n),
        .cfg_stamp_en_n(cfg_stamp_en_n), .cfg_multi_src(cfg_multi_src),
        .cfg_chan_mask(cfg_chan_mask), .cfg_half_irq_en_n(cfg_half_irq_en_n),
        .cfg_full_irq_en_n(cfg_full_irq_en_n), .ev_valid(ev_valid),
        .ev_addr(ev_addr), .fifo_full(fifo_full),
        .fifo_nearly_full(fifo_nearly_full), .fifo_half(fifo_half),
        .flag_clr_we(flag_clr_we), .flag_clr_mask(flag_clr_mask),
        .fifo_wr(fifo_wr), .fifo_data(fifo_data), .time_value(time_value),
        .lost_count(lost_count), .irq_half_flag(irq_half_flag),
        .irq_full_flag(irq_full_flag), .irq(irq)
    );

    // FIFO model: occupancy and captured words.
    always_ff @(posedge clk) begin
        if (!rst_n || drain) begin
            cnt <= '0;
        end else if (fifo_wr) begin
            cap[cnt] <= fifo_data;
            cnt <= cnt + 5'd1;
        end
    end
    assign fifo_full        = (cnt >= 5'(DEPTH));
    assign fifo_nearly_full = (cnt >= 5'(DEPTH - 2));
    assign fifo_half        = (cnt >= 5'(DEPTH / 2));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    task automatic send_ev(input logic [15:0] a);
        @(negedge clk);
        ev_valid = 1'b1;
        ev_addr  = a;
        @(negedge clk);
        ev_valid = 1'b0;
        repeat (5) @(negedge clk);
    endtask

    task automatic do_drain();
        @(negedge clk);
        drain = 1'b1;
        @(negedge clk);
        drain = 1'b0;
        @(negedge clk);
    endtask

    task automatic clear_flags(input logic [1:0] m);
        @(negedge clk);
        flag_clr_we   = 1'b1;
        flag_clr_mask = m;
        @(negedge clk);
        flag_clr_we   = 1'b0;
        flag_clr_mask = 2'b00;
    endtask

    task automatic t_reset();
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R12 fifo_wr", 32'(fifo_wr), 32'd0);
        chk("R12 time", time_value, 32'd0);
        chk("R12 flags", {30'd0, irq_full_flag, irq_half_flag}, 32'd0);
        chk("R12 irq", 32'(irq), 32'd0);
        chk("R12 lost", 32'(lost_count), 32'd0);
    endtask

    task automatic run_period(input logic [1:0] sel, input int per, input int k);
        @(negedge clk);
        cfg_time_run_n  = 1'b1;
        cfg_tick_sel    = sel;
        cfg_time_zero_n = 1'b0;
        @(negedge clk);
        chk("R5 zeroed", time_value, 32'd0);
        cfg_time_zero_n = 1'b1;
        cfg_time_run_n  = 1'b0;
        repeat (per * k + per / 2) @(negedge clk);
        chk("R4 tick count", time_value, 32'(k));
    endtask

    task automatic t_timer();
        run_period(2'b00, 50, 3);
        run_period(2'b01, 500, 2);
        run_period(2'b10, 2500, 1);
        run_period(2'b11, 5000, 1);
        cfg_time_run_n = 1'b1;
        repeat (6000) @(negedge clk);
        chk("R4 hold while stopped", time_value, 32'd1);
        run_period(2'b00, 50, 5);
        cfg_time_run_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_stamp();
        logic [31:0] t;
        do_drain();
        cfg_stamp_en_n = 1'b0;
        t = time_value;
        @(negedge clk);
        chk("R2 idle before event", 32'(fifo_wr), 32'd0);
        ev_valid = 1'b1;
        ev_addr  = 16'h1234;
        @(negedge clk);
        ev_valid = 1'b0;
        chk("R2 word1 wr", 32'(fifo_wr), 32'd1);
        chk("R1 R2 word1 time-high", 32'(fifo_data), {14'd0, 2'b01, t[31:16]});
        @(negedge clk);
        chk("R1 R2 word2 time-low", 32'(fifo_data), {14'd0, 2'b10, t[15:0]});
        @(negedge clk);
        chk("R1 R2 word3 address", 32'(fifo_data), {14'd0, 2'b00, 16'h1234});
        @(negedge clk);
        chk("R2 group ends", 32'(fifo_wr), 32'd0);
        chk("R2 three words", 32'(cnt), 32'd3);
        cfg_stamp_en_n = 1'b1;
    endtask

    task automatic t_nostamp();
        do_drain();
        cfg_stamp_en_n = 1'b1;
        @(negedge clk);
        ev_valid = 1'b1;
        ev_addr  = 16'hBEEF;
        @(negedge clk);
        ev_valid = 1'b0;
        chk("R3 address word", 32'(fifo_data), {14'd0, 2'b00, 16'hBEEF});
        chk("R3 write now", 32'(fifo_wr), 32'd1);
        @(negedge clk);
        chk("R3 single write", 32'(fifo_wr), 32'd0);
        chk("R3 one word", 32'(cnt), 32'd1);
    endtask

    task automatic t_mask();
        do_drain();
        cfg_multi_src = 1'b1;
        cfg_chan_mask = 4'b0100;
        send_ev(16'h8ABC);
        chk("R6 channel 2 ignored", 32'(cnt), 32'd0);
        chk("R6 ignored not lost", 32'(lost_count), 32'(exp_lost));
        send_ev(16'h4ABC);
        chk("R6 channel 1 stored", 32'(cnt), 32'd1);
        chk("R6 stored word", 32'(cap[0]), 32'h0_4ABC);
        cfg_multi_src = 1'b0;
        send_ev(16'h8001);
        chk("R6 single mode uses channel 0", 32'(cnt), 32'd2);
        cfg_chan_mask = 4'b0001;
        send_ev(16'h0055);
        chk("R6 channel 0 ignored", 32'(cnt), 32'd2);
        cfg_chan_mask = 4'b0000;
    endtask

    task automatic t_room();
        do_drain();
        cfg_half_irq_en_n = 1'b0;
        cfg_full_irq_en_n = 1'b1;
        cfg_stamp_en_n    = 1'b1;
        for (int i = 0; i < 14; i++) send_ev(16'(i));
        chk("R7 filled to 14", 32'(cnt), 32'd14);
        cfg_stamp_en_n = 1'b0;
        send_ev(16'h0AAA);
        exp_lost++;
        chk("R7 stamped group dropped", 32'(cnt), 32'd14);
        chk("R7 lost counted", 32'(lost_count), 32'(exp_lost));
        cfg_stamp_en_n = 1'b1;
        send_ev(16'h0BBB);
        send_ev(16'h0CCC);
        chk("R7 address fits", 32'(cnt), 32'd16);
        send_ev(16'h0DDD);
        exp_lost++;
        chk("R7 full drops", 32'(cnt), 32'd16);
        chk("R7 full lost", 32'(lost_count), 32'(exp_lost));
        chk("R9 half flag set", 32'(irq_half_flag), 32'd1);
        chk("R10 full flag disabled", 32'(irq_full_flag), 32'd0);
    endtask

    task automatic t_busy();
        do_drain();
        cfg_stamp_en_n = 1'b0;
        @(negedge clk);
        ev_valid = 1'b1;
        ev_addr  = 16'h0111;
        @(negedge clk);
        ev_addr  = 16'h0222;
        @(negedge clk);
        ev_valid = 1'b0;
        repeat (5) @(negedge clk);
        exp_lost++;
        chk("R8 only one group", 32'(cnt), 32'd3);
        chk("R8 busy event lost", 32'(lost_count), 32'(exp_lost));
        chk("R8 first address kept", 32'(cap[2]), 32'h0_0111);
        cfg_stamp_en_n = 1'b1;
    endtask

    task automatic t_flags();
        clear_flags(2'b01);
        @(negedge clk);
        chk("R11 half cleared", 32'(irq_half_flag), 32'd0);
        chk("R11 irq low", 32'(irq), 32'd0);
        do_drain();
        cfg_full_irq_en_n = 1'b0;
        for (int i = 0; i < 16; i++) send_ev(16'(i));
        chk("R10 full flag set", 32'(irq_full_flag), 32'd1);
        chk("R9 half flag set again", 32'(irq_half_flag), 32'd1);
        clear_flags(2'b10);
        @(negedge clk);
        chk("R11 full cleared", 32'(irq_full_flag), 32'd0);
        chk("R11 half kept", 32'(irq_half_flag), 32'd1);
        chk("R11 irq from half", 32'(irq), 32'd1);
        clear_flags(2'b01);
        @(negedge clk);
        chk("R11 irq clear", 32'(irq), 32'd0);
        do_drain();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete");
        report();
    end

    initial begin
        t_reset();
        t_timer();
        t_stamp();
        t_nostamp();
        t_mask();
        t_room();
        t_busy();
        do_drain();
        for (int i = 0; i < 16; i++) send_ev(16'(i));
        t_flags();
        report();
    end
endmodule